// File: doc/BRIEF.md
# Key-Protected Independent Watchdog

This block is a watchdog that runs from its own slow time base. That time base arrives as a single-cycle enable, `tick_en_i`, on the system clock: each pulse is one watchdog-clock period. Software controls the block through a four-entry register window. The window holds a key entry, a divider entry, a reload entry and a status entry. Sixteen-bit magic keys written to the key entry do three things. They open or close write access to the two configuration entries. They refill the down-counter. They start the watchdog. Once the watchdog is started, no write can stop it. If software does not refill the counter in time, the block drives a one-cycle reset pulse.

Three small state machines do the work. The lock machine has the states CLOSED and OPEN. Key 0x5555 moves it from CLOSED to OPEN, and key 0x0000 moves it from OPEN to CLOSED. The core machine has the states STOPPED, RUNNING and EXPIRE. The start key or the strap moves it from STOPPED to RUNNING. When the counter underflows it moves from RUNNING to EXPIRE. EXPIRE always returns to RUNNING on the next cycle, and only a reset returns the machine to STOPPED. Each configuration field has its own update machine with the states IDLE and BUSY. An accepted write moves it from IDLE to BUSY. After the programmed number of ticks it moves from BUSY back to IDLE, and the new value then becomes the one the counter uses.

Register addresses are fixed: 0 is the key, 1 the divider code, 2 the reload value and 3 the status.

Top module: `keyed_wdt`

## Requirements
- R1: After reset without the strap, the watchdog is stopped and writes are locked. The divider code reads 0, the reload value reads 0xFFF, status reads 0, and the reset output is low.
- R2: Writing 0x5555 to address 0 unlocks configuration writes, and writing 0x0000 locks them again. Any other key value leaves the lock state unchanged.
- R3: While locked, writes to address 1 (code in bits 2..0) and to address 2 (value in bits 11..0) are ignored, and reading those addresses returns the earlier contents.
- R4: Address 0 always reads 0x0000.
- R5: Writing 0xCCCC to address 0 starts the watchdog, so `wd_active_o` goes high. A key value other than the four defined ones starts nothing.
- R6: Once started, the watchdog stays active whatever keys or writes follow, until the next reset.
- R7: With divider code n and reload value R, the reset pulse appears (R+1)*D ticks after the start, where D = 4 shifted left by min(n,6).
- R8: Code 7 divides by 256, the same as code 6.
- R9: Writing 0xAAAA to address 0 refills the counter and clears the divider phase. The next expiry then falls (R+1)*D ticks after that write.
- R10: The reset pulse lasts exactly one cycle. Counting resumes from the reload value, so the next expiry follows (R+1)*D ticks later.
- R11: Status bit 0 (divider) and status bit 1 (reload) go high on an accepted write. Each holds while no ticks arrive and clears after UPD_TICKS ticks.
- R12: If the strap input is high during reset, the watchdog comes out of reset already running, with code 0 and reload 0xFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| strap_start_i | input | 1 | Start-at-reset strap, sampled while reset is held |
| tick_en_i | input | 1 | One pulse per watchdog-clock period |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Write address |
| wr_data_i | input | 16 | Write data |
| rd_addr_i | input | 2 | Read address |
| rd_data_o | output | 16 | Read data (combinational) |
| wd_active_o | output | 1 | Watchdog running |
| wd_rst_o | output | 1 | One-cycle expiry reset pulse |

## Verification
The bench uses the default parameters: a 3-bit divider code, a 12-bit reload value and UPD_TICKS of 3. Holding the tick enable high turns every watchdog period into one clock. With that, even the full-range strap expiry of 16384 ticks fits in the run, and small reload values reach every divider code, including the aliased code 7, within a few thousand cycles. The short update window lets the bench see the status bits rise, hold while ticks are paused, and clear on the exact tick.

// File: rtl/kwdt_pkg.sv
package kwdt_pkg;
    localparam int DATA_W = 16;
    localparam int ADDR_W = 2;

    localparam logic [DATA_W-1:0] KEY_OPEN   = 16'h5555;
    localparam logic [DATA_W-1:0] KEY_CLOSE  = 16'h0000;
    localparam logic [DATA_W-1:0] KEY_REFILL = 16'hAAAA;
    localparam logic [DATA_W-1:0] KEY_GO     = 16'hCCCC;

    localparam logic [ADDR_W-1:0] A_KEY  = 2'd0;
    localparam logic [ADDR_W-1:0] A_DIV  = 2'd1;
    localparam logic [ADDR_W-1:0] A_RLD  = 2'd2;
    localparam logic [ADDR_W-1:0] A_STAT = 2'd3;

    typedef enum logic {LK_CLOSED, LK_OPEN} lock_state_e;
    typedef enum logic {UPD_IDLE, UPD_BUSY} upd_state_e;
    typedef enum logic [1:0] {CORE_STOPPED, CORE_RUNNING, CORE_EXPIRE} core_state_e;
endpackage

// File: rtl/kwdt_keydec.sv
module kwdt_keydec
    import kwdt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    output logic              open_o,
    output logic              go_p_o,
    output logic              refill_p_o
);
    lock_state_e state_q, state_d;
    logic key_wr;

    assign key_wr = wr_en_i && (wr_addr_i == A_KEY);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= LK_CLOSED;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LK_CLOSED: if (key_wr && wr_data_i == KEY_OPEN)  state_d = LK_OPEN;
            LK_OPEN:   if (key_wr && wr_data_i == KEY_CLOSE) state_d = LK_CLOSED;
            default:   state_d = LK_CLOSED;
        endcase
    end

    // outputs
    always_comb begin
        open_o     = (state_q == LK_OPEN);
        go_p_o     = key_wr && (wr_data_i == KEY_GO);
        refill_p_o = key_wr && (wr_data_i == KEY_REFILL);
    end
endmodule

// File: rtl/kwdt_field.sv
module kwdt_field
    import kwdt_pkg::*;
#(
    parameter int          W         = 3,
    parameter logic [W-1:0] RST_VAL  = '0,
    parameter int          UPD_TICKS = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick_en_i,
    input  logic         wr_ok_i,
    input  logic [W-1:0] wr_val_i,
    output logic [W-1:0] pend_o,
    output logic [W-1:0] act_o,
    output logic         busy_o
);
    localparam int CW = $clog2(UPD_TICKS + 1);
    localparam logic [CW-1:0] LAST = CW'(UPD_TICKS - 1);

    upd_state_e     state_q, state_d;
    logic [CW-1:0]  cnt_q, cnt_d;
    logic [W-1:0]   pend_q, pend_d, act_q, act_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= UPD_IDLE;
            cnt_q   <= '0;
            pend_q  <= RST_VAL;
            act_q   <= RST_VAL;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            pend_q  <= pend_d;
            act_q   <= act_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        pend_d  = pend_q;
        act_d   = act_q;
        if (wr_ok_i) begin
            pend_d  = wr_val_i;
            state_d = UPD_BUSY;
            cnt_d   = '0;
        end else begin
            unique case (state_q)
                UPD_IDLE: ;
                UPD_BUSY: begin
                    if (tick_en_i) begin
                        if (cnt_q == LAST) begin
                            act_d   = pend_q;
                            state_d = UPD_IDLE;
                            cnt_d   = '0;
                        end else begin
                            cnt_d = cnt_q + 1'b1;
                        end
                    end
                end
                default: state_d = UPD_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        busy_o = (state_q == UPD_BUSY);
        pend_o = pend_q;
        act_o  = act_q;
    end
endmodule

// File: rtl/kwdt_core.sv
module kwdt_core
    import kwdt_pkg::*;
#(
    parameter int PR_W = 3,
    parameter int RL_W = 12
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            strap_i,
    input  logic            tick_en_i,
    input  logic            go_p_i,
    input  logic            refill_p_i,
    input  logic [PR_W-1:0] pr_code_i,
    input  logic [RL_W-1:0] rl_val_i,
    output logic            active_o,
    output logic            expire_o
);
    localparam int MAX_SHIFT = 6;
    localparam int PC_W      = MAX_SHIFT + 2;

    core_state_e      state_q, state_d;
    logic [RL_W-1:0]  cnt_q, cnt_d;
    logic [PC_W-1:0]  pcnt_q, pcnt_d;
    logic [PC_W-1:0]  phase_last;

    function automatic logic [PC_W-1:0] div_last(input logic [PR_W-1:0] code);
        int          sh;
        logic [PC_W:0] d;
        sh = (int'(code) > MAX_SHIFT) ? MAX_SHIFT : int'(code);
        d  = (PC_W+1)'(4) << sh;
        return PC_W'(d - 1'b1);
    endfunction

    assign phase_last = div_last(pr_code_i);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= strap_i ? CORE_RUNNING : CORE_STOPPED;
            cnt_q   <= '1;
            pcnt_q  <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            pcnt_q  <= pcnt_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        pcnt_d  = pcnt_q;
        unique case (state_q)
            CORE_STOPPED: begin
                if (go_p_i) begin
                    state_d = CORE_RUNNING;
                    cnt_d   = rl_val_i;
                    pcnt_d  = '0;
                end else if (refill_p_i) begin
                    cnt_d   = rl_val_i;
                end
            end
            CORE_RUNNING, CORE_EXPIRE: begin
                state_d = CORE_RUNNING;
                if (refill_p_i) begin
                    cnt_d  = rl_val_i;
                    pcnt_d = '0;
                end else if (tick_en_i) begin
                    if (pcnt_q == phase_last) begin
                        pcnt_d = '0;
                        if (cnt_q == '0) begin
                            state_d = CORE_EXPIRE;
                            cnt_d   = rl_val_i;
                        end else begin
                            cnt_d = cnt_q - 1'b1;
                        end
                    end else begin
                        pcnt_d = pcnt_q + 1'b1;
                    end
                end
            end
            default: state_d = CORE_STOPPED;
        endcase
    end

    // outputs
    always_comb begin
        active_o = (state_q != CORE_STOPPED);
        expire_o = (state_q == CORE_EXPIRE);
    end
endmodule

// File: rtl/keyed_wdt.sv
module keyed_wdt
    import kwdt_pkg::*;
#(
    parameter int PR_W      = 3,
    parameter int RL_W      = 12,
    parameter int UPD_TICKS = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strap_start_i,
    input  logic              tick_en_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              wd_active_o,
    output logic              wd_rst_o
);
    logic            key_open, go_p, refill_p;
    logic            pr_wr, rl_wr;
    logic [PR_W-1:0] pr_pend, pr_act;
    logic [RL_W-1:0] rl_pend, rl_act;
    logic            pr_busy, rl_busy;

    kwdt_keydec u_key (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en_i    (wr_en_i),
        .wr_addr_i  (wr_addr_i),
        .wr_data_i  (wr_data_i),
        .open_o     (key_open),
        .go_p_o     (go_p),
        .refill_p_o (refill_p)
    );

    assign pr_wr = wr_en_i && key_open && (wr_addr_i == A_DIV);
    assign rl_wr = wr_en_i && key_open && (wr_addr_i == A_RLD);

    kwdt_field #(.W(PR_W), .RST_VAL('0), .UPD_TICKS(UPD_TICKS)) u_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_en_i (tick_en_i),
        .wr_ok_i   (pr_wr),
        .wr_val_i  (wr_data_i[PR_W-1:0]),
        .pend_o    (pr_pend),
        .act_o     (pr_act),
        .busy_o    (pr_busy)
    );

    kwdt_field #(.W(RL_W), .RST_VAL('1), .UPD_TICKS(UPD_TICKS)) u_rld (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_en_i (tick_en_i),
        .wr_ok_i   (rl_wr),
        .wr_val_i  (wr_data_i[RL_W-1:0]),
        .pend_o    (rl_pend),
        .act_o     (rl_act),
        .busy_o    (rl_busy)
    );

    kwdt_core #(.PR_W(PR_W), .RL_W(RL_W)) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .strap_i    (strap_start_i),
        .tick_en_i  (tick_en_i),
        .go_p_i     (go_p),
        .refill_p_i (refill_p),
        .pr_code_i  (pr_act),
        .rl_val_i   (rl_act),
        .active_o   (wd_active_o),
        .expire_o   (wd_rst_o)
    );

    always_comb begin
        unique case (rd_addr_i)
            A_KEY:   rd_data_o = '0;
            A_DIV:   rd_data_o = {{(DATA_W-PR_W){1'b0}}, pr_pend};
            A_RLD:   rd_data_o = {{(DATA_W-RL_W){1'b0}}, rl_pend};
            A_STAT:  rd_data_o = {{(DATA_W-2){1'b0}}, rl_busy, pr_busy};
            default: rd_data_o = '0;
        endcase
    end
endmodule

// File: rtl/kwdt_chk.sv
module kwdt_chk
    import kwdt_pkg::*;
#(
    parameter int PR_W = 3,
    parameter int RL_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic              open,
    input logic              active,
    input logic              wd_rst,
    input logic [PR_W-1:0]   pr_pend,
    input logic [RL_W-1:0]   rl_pend,
    input logic              pr_busy
);
    p_unlock_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == A_KEY && wr_data == KEY_OPEN) |=> open);

    p_locked_div_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!open && wr_en && wr_addr == A_DIV) |=> $stable(pr_pend));

    p_locked_rld_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!open && wr_en && wr_addr == A_RLD) |=> $stable(rl_pend));

    p_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == A_KEY && wr_data == KEY_GO) |=> active);

    p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        active |=> active);

    p_rst_when_active_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wd_rst |-> active);

    p_one_cycle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wd_rst |=> !wd_rst);

    p_flag_set_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (open && wr_en && wr_addr == A_DIV) |=> pr_busy);
endmodule

bind keyed_wdt kwdt_chk #(.PR_W(PR_W), .RL_W(RL_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en_i),
    .wr_addr (wr_addr_i),
    .wr_data (wr_data_i),
    .open    (key_open),
    .active  (wd_active_o),
    .wd_rst  (wd_rst_o),
    .pr_pend (pr_pend),
    .rl_pend (rl_pend),
    .pr_busy (pr_busy)
);

// File: tb/keyed_wdt_test.sv
`timescale 1ns/1ps
module keyed_wdt_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        strap = 1'b0;
    logic        tick = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = 2'd0;
    logic [15:0] wr_data = 16'd0;
    logic [1:0]  rd_addr = 2'd0;
    logic [15:0] rd_data;
    logic        active, wdrst;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #2 clk = ~clk;

    keyed_wdt uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .strap_start_i (strap),
        .tick_en_i     (tick),
        .wr_en_i       (wr_en),
        .wr_addr_i     (wr_addr),
        .wr_data_i     (wr_data),
        .rd_addr_i     (rd_addr),
        .rd_data_o     (rd_data),
        .wd_active_o   (active),
        .wd_rst_o      (wdrst)
    );

    function automatic int div_of(int code);
        return 4 << ((code > 6) ? 6 : code);
    endfunction

    function automatic int expiry_ticks(int code, int r);
        return (r + 1) * div_of(code);
    endfunction

    task automatic chk(string req, string what, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic do_reset(bit s);
        @(negedge clk);
        rst_n = 1'b0; strap = s; wr_en = 1'b0; tick = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr(logic [1:0] a, logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(logic [1:0] a, output int v);
        rd_addr = a;
        #1;
        v = int'(rd_data);
    endtask

    task automatic configure(int code, int r);
        wr(2'd0, 16'h5555);
        wr(2'd1, 16'(code));
        wr(2'd2, 16'(r));
        tick = 1'b1;
        repeat (6) @(negedge clk);
    endtask

    // counts edges from the current negedge until the first pulse
    task automatic measure(int limit, output int first);
        first = -1;
        for (int n = 1; n <= limit; n++) begin
            @(negedge clk);
            if (wdrst) begin
                first = n;
                break;
            end
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog timeout actual=0 expected=1");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int v, first, e;
        void'($urandom(32'd20240611));

        // R1 reset state
        do_reset(1'b0);
        chk("R1", "active", int'(active), 0);
        chk("R1", "wd_rst", int'(wdrst), 0);
        rd(2'd1, v); chk("R1", "div code", v, 0);
        rd(2'd2, v); chk("R1", "reload", v, 16'hFFF);
        rd(2'd3, v); chk("R1", "status", v, 0);
        rd(2'd0, v); chk("R4", "key read", v, 0);

        // R3 locked writes ignored
        wr(2'd1, 16'd5);
        wr(2'd2, 16'h123);
        rd(2'd1, v); chk("R3", "locked div", v, 0);
        rd(2'd2, v); chk("R3", "locked reload", v, 16'hFFF);
        rd(2'd3, v); chk("R3", "locked status", v, 0);

        // R2 a stray key does not unlock
        wr(2'd0, 16'h1234);
        wr(2'd1, 16'd3);
        rd(2'd1, v); chk("R2", "stray key keeps lock", v, 0);
        chk("R5", "stray key no start", int'(active), 0);

        // R2 unlock, R11 flag behaviour
        wr(2'd0, 16'h5555);
        rd(2'd0, v); chk("R4", "key read after unlock", v, 0);
        wr(2'd1, 16'd2);
        rd(2'd1, v); chk("R2", "unlocked div write", v, 2);
        rd(2'd3, v); chk("R11", "div flag set", v, 1);
        repeat (4) @(negedge clk);
        rd(2'd3, v); chk("R11", "flag holds without ticks", v, 1);
        tick = 1'b1;
        repeat (2) @(negedge clk);
        rd(2'd3, v); chk("R11", "flag before last tick", v, 1);
        @(negedge clk);
        rd(2'd3, v); chk("R11", "flag cleared", v, 0);
        tick = 1'b0;
        wr(2'd2, 16'h00A);
        rd(2'd3, v); chk("R11", "reload flag set", v, 2);
        tick = 1'b1;
        repeat (3) @(negedge clk);
        rd(2'd3, v); chk("R11", "reload flag cleared", v, 0);

        // R2 relock
        wr(2'd0, 16'h0000);
        wr(2'd2, 16'h077);
        rd(2'd2, v); chk("R2", "relocked reload", v, 16'h00A);
        wr(2'd0, 16'hBEEF);
        chk("R5", "unknown key no start", int'(active), 0);

        // R7 R10 basic expiry, code 0 reload 5
        do_reset(1'b0);
        configure(0, 5);
        rd(2'd3, v); chk("R11", "status idle before start", v, 0);
        wr(2'd0, 16'hCCCC);
        chk("R5", "started", int'(active), 1);
        e = expiry_ticks(0, 5);
        measure(e + 10, first);
        chk("R7", "first expiry code0 r5", first, e);
        @(negedge clk);
        chk("R10", "pulse one cycle", int'(wdrst), 0);
        measure(e + 10, first);
        chk("R10", "second expiry", first, e - 1);

        // R6 cannot be stopped
        wr(2'd0, 16'h0000);
        wr(2'd0, 16'h1234);
        wr(2'd0, 16'h5555);
        wr(2'd1, 16'd4);
        chk("R6", "still active", int'(active), 1);

        // R9 refill key
        do_reset(1'b0);
        configure(1, 3);
        wr(2'd0, 16'hCCCC);
        repeat (20) @(negedge clk);
        chk("R9", "no pulse before refill", int'(wdrst), 0);
        wr(2'd0, 16'hAAAA);
        e = expiry_ticks(1, 3);
        measure(e + 10, first);
        chk("R9", "expiry after refill", first, e);

        // R8 code 7 aliases code 6
        do_reset(1'b0);
        configure(7, 1);
        wr(2'd0, 16'hCCCC);
        measure(600, first);
        chk("R8", "code 7 divide", first, 512);
        do_reset(1'b0);
        configure(6, 1);
        wr(2'd0, 16'hCCCC);
        measure(600, first);
        chk("R8", "code 6 divide", first, 512);

        // R7 random trials
        for (int t = 0; t < 6; t++) begin
            int code, r;
            code = int'($urandom % 8);
            r    = int'($urandom % 16);
            do_reset(1'b0);
            configure(code, r);
            wr(2'd0, 16'hCCCC);
            e = expiry_ticks(code, r);
            measure(e + 10, first);
            chk("R7", $sformatf("random code=%0d r=%0d", code, r), first, e);
        end

        // R12 strap start
        do_reset(1'b1);
        chk("R12", "active from strap", int'(active), 1);
        tick = 1'b1;
        strap = 1'b0;
        measure(16400, first);
        chk("R12", "strap default expiry", first, 16384);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule